// File: doc/BRIEF.md
# Two-Channel DMA Termination Controller

This block sequences memory-to-memory copies for two channels over one shared master bus. A channel copies one word per pair of bus cycles. The first cycle reads from the source address and the second writes that word to the destination address. Both addresses then step up by one, and the channel repeats until its programmed count reaches zero. Channel 0 wins when both channels are ready. The choice is made only between complete read-and-write pairs.

Each channel records how its transfer finished in three status bits: a request bit, an error bit and a phase bit. A finish is one of normal completion, an error response from the bus, or a pause requested through the channel's mask bit. Software writes the source, destination, count and mask through a small write port. It clears status through a per-channel clear strobe and reads both channels' status from one shared word. The mask bit does two jobs. It hides the channel's completion from the interrupt line, and it parks a running transfer at the next write-cycle boundary. Dropping the mask resumes the transfer where it stopped.

Top module: `dma2_term_ctrl`

## Requirements
- R1: When a channel's count is used up by successful writes, the channel stops and sets its request bit. Its error and phase bits keep their previous values.
- R2: An error response (`m_err` high while `m_req` is high) on a read or a write stops the channel at once, with no further bus cycle. The same edge sets both the channel's request bit and its error bit.
- R3: On an error, the channel's phase bit records the failing cycle: 0 for a read, 1 for a write.
- R4: `irq_o` goes high one clock after any channel has its request bit at 1 while its mask is 0. It stays high until no such channel remains. A completion that happens while the channel is masked does not raise `irq_o` until the mask is dropped.
- R5: Writing mask = 1 (`cfg_sel` = 3, data bit 0) while a transfer runs lets the current pair finish its write. After that no read is started for the channel, and the pause sets no status bit.
- R6: Writing mask = 0 resumes a paused channel with its remaining count and its current addresses.
- R7: A pulse on `clr_i[c]` zeroes channel c's request, error and phase bits. If a status-setting event lands in the same cycle, the event wins.
- R8: `stat_o[2:0]` holds channel 0's {phase, error, request} and `stat_o[5:3]` holds channel 1's, with request in the low bit of each group.
- R9: Writing a count of 0 (`cfg_sel` = 2) starts no bus cycle and sets no status.
- R10: When both channels are ready at a pair boundary, channel 0 runs its pair first. A pair that has begun is never interrupted by the other channel.
- R11: Each pair reads at the channel's source address and then writes the read data to its destination address. Both addresses then increase by 1. Address, direction and data stay stable while `m_ready` and `m_err` are low.
- R12: After reset, all status bits, `irq_o` and `m_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 1 | Channel selected by the write |
| cfg_sel | input | 2 | 0 source, 1 destination, 2 count (starts the channel), 3 mask |
| cfg_wdata | input | AW | Write data; the count uses the low CW bits and the mask uses bit 0 |
| clr_i | input | 2 | Per-channel status clear strobe |
| stat_o | output | 6 | Shared status word |
| irq_o | output | 1 | Interrupt request |
| m_req | output | 1 | Bus cycle request |
| m_we | output | 1 | 1 = write cycle, 0 = read cycle |
| m_addr | output | AW | Bus address |
| m_wdata | output | DW | Write data |
| m_rdata | input | DW | Read data |
| m_ready | input | 1 | Cycle completed |
| m_err | input | 1 | Cycle completed with an error |

## Verification
Two events can coincide here. A status-setting event, either the final write or an error, can land in the same cycle as a software clear. A mask write can also land while a pair is still in its read or write cycle. The bench provokes the first by holding the clear strobe high through a whole transfer, so the completion edge meets a clear, and expects the request bit to be set for exactly one cycle. It provokes the second by writing the mask during a wait-stated pair, and judges on every clock against a behavioural model. That model allows no new read, adds no status and keeps the remaining count.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RD   = 2'd1,
    ENG_WR   = 2'd2
  } eng_state_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_MASK = 2'd3;

  typedef struct packed {
    logic ph;
    logic err;
    logic req;
  } ch_stat_t;

endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
  import dma2_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          clr,
  input  logic          step_ok,
  input  logic          fail,
  input  logic          fail_ph,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          ready_o,
  output logic          mask_o,
  output ch_stat_t      stat_o
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          act_q, mask_q;
  ch_stat_t      stat_q;
  logic          last_step;

  assign last_step = step_ok && (cnt_q == CNT_ONE);

  // programming, address stepping and count
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          SEL_SRC:  src_q  <= cfg_wdata;
          SEL_DST:  dst_q  <= cfg_wdata;
          SEL_CNT: begin
            cnt_q <= cfg_wdata[CW-1:0];
            act_q <= |cfg_wdata[CW-1:0];
          end
          default:  mask_q <= cfg_wdata[0];
        endcase
      end
      if (step_ok) begin
        src_q <= src_q + AW'(1);
        dst_q <= dst_q + AW'(1);
        cnt_q <= cnt_q - CNT_ONE;
        if (cnt_q == CNT_ONE) act_q <= 1'b0;
      end
      if (fail) act_q <= 1'b0;
    end
  end

  // termination status: a set in the same cycle overrides a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      if (clr) stat_q <= '0;
      if (last_step) stat_q.req <= 1'b1;
      if (fail) begin
        stat_q.req <= 1'b1;
        stat_q.err <= 1'b1;
        stat_q.ph  <= fail_ph;
      end
    end
  end

  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign ready_o = act_q && !mask_q;
  assign mask_o  = mask_q;
  assign stat_o  = stat_q;

endmodule

// File: rtl/dma2_arb.sv
module dma2_arb #(
  parameter int N = 2
) (
  input  logic [N-1:0] ready_i,
  output logic [N-1:0] grant_o
);

  // lowest index wins
  always_comb begin
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ready_i[i]) grant_o = N'(1) << i;
    end
  end

endmodule

// File: rtl/dma2_engine.sv
module dma2_engine
  import dma2_pkg::*;
#(
  parameter int N  = 2,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         grant_i,
  input  logic [N-1:0][AW-1:0] src_i,
  input  logic [N-1:0][AW-1:0] dst_i,
  output logic [N-1:0]         step_o,
  output logic [N-1:0]         fail_o,
  output logic                 fail_ph_o,
  output logic                 m_req,
  output logic                 m_we,
  output logic [AW-1:0]        m_addr,
  output logic [DW-1:0]        m_wdata,
  input  logic [DW-1:0]        m_rdata,
  input  logic                 m_ready,
  input  logic                 m_err
);

  localparam int CH_W = (N > 1) ? $clog2(N) : 1;

  eng_state_e      st_q;
  logic [CH_W-1:0] cur_q, pick;

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (grant_i[i]) pick = CH_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ENG_IDLE;
      cur_q   <= '0;
      m_req   <= 1'b0;
      m_we    <= 1'b0;
      m_addr  <= '0;
      m_wdata <= '0;
    end else begin
      case (st_q)
        ENG_IDLE: begin
          if (|grant_i) begin
            st_q   <= ENG_RD;
            cur_q  <= pick;
            m_req  <= 1'b1;
            m_we   <= 1'b0;
            m_addr <= src_i[pick];
          end
        end
        ENG_RD: begin
          if (m_err) begin
            st_q  <= ENG_IDLE;
            m_req <= 1'b0;
          end else if (m_ready) begin
            st_q    <= ENG_WR;
            m_we    <= 1'b1;
            m_addr  <= dst_i[cur_q];
            m_wdata <= m_rdata;
          end
        end
        default: begin
          if (m_err || m_ready) begin
            st_q  <= ENG_IDLE;
            m_req <= 1'b0;
            m_we  <= 1'b0;
          end
        end
      endcase
    end
  end

  always_comb begin
    step_o = '0;
    fail_o = '0;
    if (st_q == ENG_WR && m_ready && !m_err) step_o[cur_q] = 1'b1;
    if (st_q != ENG_IDLE && m_err) fail_o[cur_q] = 1'b1;
  end

  assign fail_ph_o = (st_q == ENG_WR);

endmodule

// File: rtl/dma2_term_ctrl.sv
module dma2_term_ctrl
  import dma2_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_ch,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic [1:0]    clr_i,
  output logic [5:0]    stat_o,
  output logic          irq_o,
  output logic          m_req,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  input  logic          m_ready,
  input  logic          m_err
);

  localparam int NCH = 2;

  logic [NCH-1:0][AW-1:0] src_v, dst_v;
  logic [NCH-1:0]         rdy_v, mask_v, req_v, grant, step, fail;
  logic                   fail_ph;
  ch_stat_t [NCH-1:0]     st_v;
  logic                   irq_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma2_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (cfg_we && (cfg_ch == 1'(c))),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .clr      (clr_i[c]),
      .step_ok  (step[c]),
      .fail     (fail[c]),
      .fail_ph  (fail_ph),
      .src_o    (src_v[c]),
      .dst_o    (dst_v[c]),
      .ready_o  (rdy_v[c]),
      .mask_o   (mask_v[c]),
      .stat_o   (st_v[c])
    );
    assign req_v[c]           = st_v[c].req;
    assign stat_o[3*c +: 3]   = st_v[c];
  end

  dma2_arb #(.N(NCH)) u_arb (
    .ready_i(rdy_v),
    .grant_o(grant)
  );

  dma2_engine #(.N(NCH), .AW(AW), .DW(DW)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .grant_i  (grant),
    .src_i    (src_v),
    .dst_i    (dst_v),
    .step_o   (step),
    .fail_o   (fail),
    .fail_ph_o(fail_ph),
    .m_req    (m_req),
    .m_we     (m_we),
    .m_addr   (m_addr),
    .m_wdata  (m_wdata),
    .m_rdata  (m_rdata),
    .m_ready  (m_ready),
    .m_err    (m_err)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(req_v & ~mask_v);
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/dma2_term_chk.sv
module dma2_term_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          m_req,
  input logic          m_we,
  input logic          m_ready,
  input logic          m_err,
  input logic [AW-1:0] m_addr,
  input logic [5:0]    stat_o,
  input logic          irq_o
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!m_req && !irq_o && stat_o == 6'd0)); // R12

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_err) |=> !m_req); // R2

  AST_RD_ERR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_err && !m_we) |=> (stat_o[1] || stat_o[4])); // R2

  AST_WR_ERR_PHASE: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_err && m_we) |=> (stat_o[2] || stat_o[5])); // R3

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(stat_o[0] || stat_o[3])); // R4

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_we && m_ready && !m_err) |=> (m_req && m_we)); // R11

  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ready && !m_err) |=> (m_req && $stable(m_addr) && $stable(m_we))); // R11

endmodule

bind dma2_term_ctrl dma2_term_chk #(.AW(AW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .m_req  (m_req),
  .m_we   (m_we),
  .m_ready(m_ready),
  .m_err  (m_err),
  .m_addr (m_addr),
  .stat_o (stat_o),
  .irq_o  (irq_o)
);

// File: tb/sim_dma2_term_ctrl.sv
`timescale 1ns/1ps
module sim_dma2_term_ctrl;
  localparam int AW = 16, DW = 16, CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_ch = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [1:0] clr_i = '0;
  logic [5:0] stat_o;
  logic irq_o, m_req, m_we;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata;
  logic [DW-1:0] m_rdata = '0;
  logic m_ready = 1'b0, m_err = 1'b0;

  always #4 clk = ~clk;

  dma2_term_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u0 (.*);

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model state
  int  ms_src[2], ms_dst[2], ms_cnt[2], pairs[2];
  bit  ms_act[2], ms_msk[2], ms_rq[2], ms_er[2], ms_ph[2];
  bit  prev_f = 0;
  int  txn_ch = -1;
  bit  irq_seen = 0;

  // responder controls
  bit waits_on = 1, arm_rd = 0, arm_wr = 0;
  int wc = 0;

  // edge captures
  bit cap_rst, cap_we, cap_ch, cap_req, cap_mwe, cap_rdy, cap_err;
  bit [1:0] cap_sel, cap_clr;
  logic [AW-1:0] cap_wd, cap_addr;
  logic [DW-1:0] cap_mwd;

  always @(posedge clk) begin
    cap_rst  <= rst;     cap_we  <= cfg_we;  cap_ch  <= cfg_ch;
    cap_sel  <= cfg_sel; cap_wd  <= cfg_wdata; cap_clr <= clr_i;
    cap_req  <= m_req;   cap_mwe <= m_we;    cap_rdy <= m_ready;
    cap_err  <= m_err;   cap_addr <= m_addr; cap_mwd <= m_wdata;
  end

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return DW'(a) ^ 16'hA5C3;
  endfunction

  // bus responder
  always @(negedge clk) begin
    m_ready = 1'b0;
    m_err   = 1'b0;
    if (!rst && m_req) begin
      if (wc > 0) wc--;
      else begin
        if (!m_we && arm_rd) begin m_err = 1'b1; arm_rd = 0; end
        else if (m_we && arm_wr) begin m_err = 1'b1; arm_wr = 0; end
        else m_ready = 1'b1;
        wc = waits_on ? int'($urandom_range(0, 3)) : 0;
      end
    end
    m_rdata = mem_val(m_addr);
  end

  // model update and per-cycle comparison
  int pc;
  logic [5:0] expw;
  always @(negedge clk) begin
    if (cap_rst) begin
      for (int c = 0; c < 2; c++) begin
        ms_src[c] = 0; ms_dst[c] = 0; ms_cnt[c] = 0;
        ms_act[c] = 0; ms_msk[c] = 0; ms_rq[c] = 0; ms_er[c] = 0; ms_ph[c] = 0;
      end
      prev_f = 0; txn_ch = -1;
    end else begin
      if (m_req && txn_ch < 0) begin
        pc = (ms_act[0] && !ms_msk[0]) ? 0 : ((ms_act[1] && !ms_msk[1]) ? 1 : -1);
        if (pc < 0) chk(0, "R5 read started with no runnable channel", int'(m_addr), 0);
        else begin
          chk(m_we == 1'b0, "R11 pair opens with a read", int'(m_we), 0);
          chk(int'(m_addr) == ms_src[pc], "R10 R11 read address of chosen channel",
              int'(m_addr), ms_src[pc]);
        end
        txn_ch = (pc < 0) ? 0 : pc;
      end
      for (int c = 0; c < 2; c++)
        if (cap_clr[c]) begin ms_rq[c] = 0; ms_er[c] = 0; ms_ph[c] = 0; end
      if (cap_we) begin
        case (cap_sel)
          2'd0: ms_src[cap_ch] = int'(cap_wd);
          2'd1: ms_dst[cap_ch] = int'(cap_wd);
          2'd2: begin ms_cnt[cap_ch] = int'(cap_wd[CW-1:0]); ms_act[cap_ch] = (cap_wd[CW-1:0] != 0); end
          default: ms_msk[cap_ch] = cap_wd[0];
        endcase
      end
      if (cap_req && (cap_rdy || cap_err) && txn_ch >= 0) begin
        pc = txn_ch;
        if (cap_err) begin
          ms_rq[pc] = 1; ms_er[pc] = 1; ms_ph[pc] = cap_mwe; ms_act[pc] = 0; txn_ch = -1;
        end else if (cap_mwe) begin
          chk(int'(cap_addr) == ms_dst[pc], "R11 write address", int'(cap_addr), ms_dst[pc]);
          chk(cap_mwd == mem_val(AW'(ms_src[pc])), "R11 write data equals read data",
              int'(cap_mwd), int'(mem_val(AW'(ms_src[pc]))));
          ms_src[pc] = (ms_src[pc] + 1) & 16'hFFFF;
          ms_dst[pc] = (ms_dst[pc] + 1) & 16'hFFFF;
          ms_cnt[pc]--; pairs[pc]++;
          if (ms_cnt[pc] == 0) begin ms_act[pc] = 0; ms_rq[pc] = 1; end
          txn_ch = -1;
        end
      end
      for (int c = 0; c < 2; c++) expw[3*c +: 3] = {ms_ph[c], ms_er[c], ms_rq[c]};
      chk(stat_o == expw, "R8 status word vs model", int'(stat_o), int'(expw));
      chk(irq_o == prev_f, "R4 irq vs model", int'(irq_o), int'(prev_f));
      if (irq_o) irq_seen = 1;
      prev_f = (ms_rq[0] && !ms_msk[0]) || (ms_rq[1] && !ms_msk[1]);
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic wr(input bit ch, input bit [1:0] sel, input int v);
    tick(); cfg_we = 1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = AW'(v);
    tick(); cfg_we = 0;
  endtask

  task automatic clr(input bit [1:0] m);
    tick(); clr_i = m; tick(); clr_i = 0;
  endtask

  task automatic start(input bit ch, input int s, input int d, input int n);
    wr(ch, 2'd0, s); wr(ch, 2'd1, d); wr(ch, 2'd2, n);
  endtask

  task automatic wait_idle();
    int t = 0;
    do begin tick(); t++; end
    while (!(txn_ch < 0 && !m_req && !(ms_act[0] && !ms_msk[0]) && !(ms_act[1] && !ms_msk[1]))
           && t < 4000);
    if (t >= 4000) chk(0, "R1 transfer never finished", t, 0);
    tick(); tick();
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "R1 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pairs[0] = 0; pairs[1] = 0;
    repeat (5) tick();
    rst = 0;
    tick();
    chk(stat_o == 0, "R12 status after reset", int'(stat_o), 0);
    chk(irq_o == 0, "R12 irq after reset", int'(irq_o), 0);
    chk(m_req == 0, "R12 no bus cycle after reset", int'(m_req), 0);

    // normal completion
    start(0, 16'h1000, 16'h2000, 3);
    wait_idle();
    chk(pairs[0] == 3, "R1 pair count", pairs[0], 3);
    chk(stat_o[2:0] == 3'b001, "R1 only request set", int'(stat_o[2:0]), 1);
    chk(irq_o == 1, "R4 irq on completion", int'(irq_o), 1);
    clr(2'b01);
    chk(stat_o[2:0] == 0, "R7 clear", int'(stat_o[2:0]), 0);
    tick();
    chk(irq_o == 0, "R4 irq drops after clear", int'(irq_o), 0);

    // read error on channel 1
    pairs[1] = 0;
    start(1, 16'h5000, 16'h6000, 4);
    while (pairs[1] < 2) tick();
    arm_rd = 1;
    wait_idle();
    chk(pairs[1] == 2, "R2 stops at read error", pairs[1], 2);
    chk(stat_o[5:3] == 3'b011, "R3 read error phase 0", int'(stat_o[5:3]), 3);
    clr(2'b10);

    // write error on channel 0, then a normal run keeps err
    pairs[0] = 0;
    arm_wr = 1;
    start(0, 16'h1100, 16'h2100, 3);
    wait_idle();
    chk(pairs[0] == 0, "R2 stops at write error", pairs[0], 0);
    chk(stat_o[2:0] == 3'b111, "R3 write error phase 1", int'(stat_o[2:0]), 7);
    start(0, 16'h1200, 16'h2200, 1);
    wait_idle();
    chk(stat_o[2:0] == 3'b111, "R1 error bits kept on completion", int'(stat_o[2:0]), 7);
    clr(2'b01);

    // priority: channel 1 loaded while channel 0 is mid-transfer
    pairs[0] = 0; pairs[1] = 0;
    start(0, 16'h1300, 16'h2300, 4);
    while (txn_ch != 0) tick();
    start(1, 16'h5300, 16'h6300, 3);
    wait_idle();
    chk(pairs[0] == 4 && pairs[1] == 3, "R10 both channels finish", pairs[0]*16 + pairs[1], 16'h43);
    clr(2'b11);

    // suspend and resume
    pairs[0] = 0;
    start(0, 16'h1400, 16'h2400, 6);
    while (pairs[0] < 2) tick();
    wr(0, 2'd3, 1);
    repeat (40) tick();
    chk(m_req == 0, "R5 no bus cycle while paused", int'(m_req), 0);
    chk(pairs[0] < 6, "R5 transfer paused early", pairs[0], 5);
    chk(stat_o[2:0] == 0 && irq_o == 0, "R5 pause sets nothing", int'({irq_o, stat_o[2:0]}), 0);
    wr(0, 2'd3, 0);
    wait_idle();
    chk(pairs[0] == 6, "R6 resumed to full count", pairs[0], 6);
    clr(2'b01);

    // count of zero
    pairs[1] = 0;
    start(1, 16'h5500, 16'h6500, 0);
    repeat (20) tick();
    chk(pairs[1] == 0 && m_req == 0, "R9 no transfer for zero count", pairs[1], 0);
    chk(stat_o[5:3] == 0, "R9 no status for zero count", int'(stat_o[5:3]), 0);

    // clear held across the completion edge
    waits_on = 0; irq_seen = 0;
    start(1, 16'h5600, 16'h6600, 2);
    tick(); clr_i = 2'b10;
    wait_idle();
    clr_i = 0; tick();
    chk(stat_o[5:3] == 0, "R7 clear after coincident set", int'(stat_o[5:3]), 0);
    chk(irq_seen == 1, "R7 set wins over same-cycle clear", int'(irq_seen), 1);
    waits_on = 1;

    // completion while masked
    start(0, 16'h1700, 16'h2700, 1);
    wr(0, 2'd3, 1);
    repeat (30) tick();
    chk(stat_o[0] == 1, "R4 masked completion sets request", int'(stat_o[0]), 1);
    chk(irq_o == 0, "R4 masked completion silent", int'(irq_o), 0);
    wr(0, 2'd3, 0);
    tick();
    chk(irq_o == 1, "R4 irq after unmask", int'(irq_o), 1);
    clr(2'b01);
    repeat (3) tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule